// File: doc/BRIEF.md
# Pipelined ADC Acquisition Sequencer

This block runs acquisitions on an eight-channel, 12-bit serial analog-to-digital converter. The converter's channel select is pipelined: the channel address shifted out during one serial frame is the one it converts in the following frame. A host writes one command byte that carries a channel number and a mode bit. The write starts an acquisition, and while it runs the status bit in the command readback reads 0. When the 12-bit result has been captured, the status bit goes to 1 and the result is readable as two zero-extended bytes.

The block has two modes. Double-cycle mode runs a priming frame followed by a converting frame, so the result always belongs to the channel just commanded. Single-cycle mode runs one frame and returns the conversion of the channel sent in the previous frame. A host that steps through channels in a known order can use it to sample at twice the rate. The serial clock is derived from the system clock by a parameterised divider, so one frame fits the converter's timing budget.

Top module: `adc_seq`

## Requirements
- R1: After reset the command readback is 8'h80 (idle, channel 0, double-cycle mode), both result bytes are 0, chip-select is high and the serial clock is low.
- R2: A command write while idle starts an acquisition. The readback then shows channel in bits [2:0] and mode in bit 4 as written. Bits 3, 5 and 6 read 0, and a 1 written to bit 7 has no effect.
- R3: Readback bit 7 is 0 for the whole acquisition, including every frame and the gap between frames. It returns to 1 only when the result is captured.
- R4: Every frame holds chip-select low for exactly 16 rising edges of the serial clock. Each half-period of the serial clock lasts CLK_DIV system clocks. The serial clock is low whenever chip-select is high.
- R5: Each frame shifts out a control byte MSB first on the first 8 serial clocks, with the channel in control-byte bits [5:3] and all other bits 0. The data output is 0 for the last 8 clocks and whenever chip-select is high.
- R6: Single-cycle mode (bit 4 = 1) runs one frame, busy for 32*CLK_DIV clocks. Its result is the conversion of the channel sent in the previous frame (channel 0 before any frame).
- R7: Double-cycle mode (bit 4 = 0) runs two frames separated by CLK_DIV clocks of chip-select high, busy for 65*CLK_DIV clocks. Its result is the conversion of the commanded channel.
- R8: Input bits are sampled MSB first on each rising serial clock. The last 12 bits of the final frame form the result: the low result byte is bits [7:0], and the high byte is bits [11:8] with its top four bits 0. The first four input bits are discarded. The result bytes do not change while busy.
- R9: A command write while busy is ignored: the readback, the frame count, the busy time and the channel sent all stay as for the running acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte: channel [2:0], single-cycle mode bit 4 |
| cmd_rdata | output | 8 | Command readback with ready status in bit 7 |
| res_lo | output | 8 | Result bits [7:0] |
| res_hi | output | 8 | Result bits [11:8], upper nibble zero |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low converter chip-select |
| mosi | output | 1 | Serial control data to the converter |
| miso | input | 1 | Serial conversion data from the converter |

## Verification
The bench builds the block with CLK_DIV = 3. That makes a single-cycle acquisition 96 clocks and a double one 195 clocks, so many acquisitions fit in a short run. An odd divider also exposes off-by-one errors in the half-period counter and the inter-frame gap as exact busy-time mismatches. The converter model drives four junk bits ahead of the 12 data bits and applies a one-frame channel lag. Command sequences that repeat, change and alternate modes therefore show whether the result follows the previous or the current channel.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CLK_DIV    = 18,
  parameter int FRAME_BITS = 16,
  parameter int CTRL_BITS  = 8,
  parameter int DATA_BITS  = 12,
  parameter int CH_LSB     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wdata,
  output logic [7:0] cmd_rdata,
  output logic [7:0] res_lo,
  output logic [7:0] res_hi,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);

  localparam int DIV_W    = $clog2(CLK_DIV + 1);
  localparam int BIT_W    = $clog2(FRAME_BITS + 1);
  localparam int CH_BITS  = 3;
  localparam int MODE_BIT = 4;
  localparam int CH_POS   = FRAME_BITS - CTRL_BITS + CH_LSB;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} state_t;

  state_t                 state;
  logic [DIV_W-1:0]       div_cnt;
  logic [BIT_W-1:0]       bit_cnt;
  logic                   high_half;
  logic                   second_pend;
  logic [CH_BITS-1:0]     ch_q;
  logic                   single_q;
  logic [FRAME_BITS-1:0]  tx_sr;
  logic [DATA_BITS-1:0]   rx_sr;
  logic [DATA_BITS-1:0]   result_q;
  logic [15:0]            result_ext;
  logic                   tick;
  logic                   last_bit;
  logic                   unused_bits;

  function automatic logic [FRAME_BITS-1:0] ctrl_word(input logic [CH_BITS-1:0] ch);
    logic [FRAME_BITS-1:0] w;
    w = '0;
    w[CH_POS +: CH_BITS] = ch;
    return w;
  endfunction

  assign tick     = (div_cnt == DIV_W'(CLK_DIV - 1));
  assign last_bit = (bit_cnt == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      div_cnt     <= '0;
      bit_cnt     <= '0;
      high_half   <= 1'b0;
      second_pend <= 1'b0;
      ch_q        <= '0;
      single_q    <= 1'b0;
      tx_sr       <= '0;
      rx_sr       <= '0;
      result_q    <= '0;
      sclk        <= 1'b0;
      cs_n        <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmd_we) begin
            ch_q        <= cmd_wdata[CH_BITS-1:0];
            single_q    <= cmd_wdata[MODE_BIT];
            second_pend <= !cmd_wdata[MODE_BIT];
            tx_sr       <= ctrl_word(cmd_wdata[CH_BITS-1:0]);
            div_cnt     <= '0;
            bit_cnt     <= '0;
            high_half   <= 1'b0;
            cs_n        <= 1'b0;
            state       <= S_FRAME;
          end
        end
        S_FRAME: begin
          div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
          if (tick) begin
            if (!high_half) begin
              sclk      <= 1'b1;
              high_half <= 1'b1;
              rx_sr     <= {rx_sr[DATA_BITS-2:0], miso};
            end else begin
              sclk      <= 1'b0;
              high_half <= 1'b0;
              if (last_bit) begin
                cs_n <= 1'b1;
                tx_sr <= '0;
                if (second_pend) begin
                  second_pend <= 1'b0;
                  state       <= S_GAP;
                end else begin
                  result_q <= rx_sr;
                  state    <= S_IDLE;
                end
              end else begin
                bit_cnt <= bit_cnt + BIT_W'(1);
                tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
              end
            end
          end
        end
        S_GAP: begin
          div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
          if (tick) begin
            tx_sr     <= ctrl_word(ch_q);
            bit_cnt   <= '0;
            high_half <= 1'b0;
            cs_n      <= 1'b0;
            state     <= S_FRAME;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mosi        = !cs_n && tx_sr[FRAME_BITS-1];
  assign cmd_rdata   = {state == S_IDLE, 2'b00, single_q, 1'b0, ch_q};
  assign result_ext  = 16'(result_q);
  assign res_lo      = result_ext[7:0];
  assign res_hi      = result_ext[15:8];
  assign unused_bits = ^{cmd_wdata[7:5], cmd_wdata[3]};

endmodule

module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] cmd_wdata,
  input logic [7:0] cmd_rdata,
  input logic [7:0] res_lo,
  input logic [7:0] res_hi,
  input logic       sclk,
  input logic       cs_n,
  input logic       mosi
);
  logic unused_chk;
  assign unused_chk = ^{cmd_wdata[7:5], cmd_wdata[3]};

  // R3
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !cmd_rdata[7]);

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R5
  mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);

  // R2
  start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_rdata[7]) |=> (!cmd_rdata[7]
      && cmd_rdata[2:0] == $past(cmd_wdata[2:0])
      && cmd_rdata[4] == $past(cmd_wdata[4])));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_rdata[7]) |=> (cmd_rdata[4:0] == $past(cmd_rdata[4:0])));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdata[7] |-> ($stable(res_lo) && $stable(res_hi)));
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .cmd_rdata(cmd_rdata), .res_lo(res_lo), .res_hi(res_hi),
  .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;
  localparam int D = 3;
  localparam int NV = 8;
  // {command byte, expected converted channel}
  localparam logic [10:0] VEC [NV] = '{
    {8'h05, 3'd5}, {8'h12, 3'd5}, {8'h17, 3'd2}, {8'h17, 3'd7},
    {8'h00, 3'd0}, {8'h7B, 3'd0}, {8'h86, 3'd6}, {8'h11, 3'd6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic [7:0] cmd_rdata, res_lo, res_hi;
  logic sclk, cs_n, mosi;
  logic miso = 1'b0;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_seq #(.CLK_DIV(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .res_lo(res_lo), .res_hi(res_hi),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  function automatic logic [11:0] conv_val(input logic [2:0] c);
    return 12'hA5C ^ {c, c, c, c};
  endfunction

  // converter model with one-frame channel lag
  logic [2:0]  conv_ch = 3'd0;
  logic [15:0] tx_word, rx_word, last_rx;
  int bit_idx, rises, last_rises, frames = 0;
  bit in_frame = 1'b0;

  always @(negedge cs_n) begin
    in_frame = 1'b1;
    bit_idx = 0;
    rises = 0;
    rx_word = '0;
    tx_word = {4'hF, conv_val(conv_ch)};
    miso = tx_word[15];
  end
  always @(posedge sclk) if (!cs_n) begin
    rx_word = {rx_word[14:0], mosi};
    rises++;
  end
  always @(negedge sclk) if (!cs_n) begin
    bit_idx++;
    if (bit_idx < 16) miso = tx_word[15 - bit_idx];
  end
  always @(posedge cs_n) if (in_frame) begin
    in_frame = 1'b0;
    conv_ch = rx_word[13:11];
    last_rx = rx_word;
    last_rises = rises;
    frames++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic acq(input logic [7:0] cmd, input int inj_at, input logic [7:0] inj,
                     output int busy, output int nfr);
    int f0;
    f0 = frames;
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wdata = cmd;
    @(negedge clk);
    cmd_we = 1'b0;
    busy = 0;
    while (!cmd_rdata[7] && busy < 5000) begin
      busy++;
      if (cs_n === 1'b0 && cmd_rdata[7]) chk(0, "R3 ready during frame", 1, 0);
      if (inj_at > 0 && busy == inj_at) begin
        cmd_we = 1'b1;
        cmd_wdata = inj;
      end else cmd_we = 1'b0;
      @(negedge clk);
    end
    cmd_we = 1'b0;
    nfr = frames - f0;
  endtask

  task automatic check_acq(input logic [7:0] cmd, input logic [2:0] exp_ch,
                           input int busy, input int nfr);
    logic [11:0] v;
    bit single;
    single = cmd[4];
    v = conv_val(exp_ch);
    chk(cmd_rdata == ((cmd & 8'h17) | 8'h80), "R2 readback", cmd_rdata, (cmd & 8'h17) | 8'h80);
    chk(nfr == (single ? 1 : 2), single ? "R6 frames" : "R7 frames", nfr, single ? 1 : 2);
    chk(busy == (single ? 32*D : 65*D), single ? "R6 busy" : "R7 busy/R3",
        busy, single ? 32*D : 65*D);
    chk(res_lo == v[7:0], single ? "R6 R8 res_lo" : "R7 R8 res_lo", res_lo, v[7:0]);
    chk(res_hi == {4'h0, v[11:8]}, "R8 res_hi", res_hi, {4'h0, v[11:8]});
    chk(last_rx == {2'b00, cmd[2:0], 11'b0}, "R5 control word", last_rx, {2'b00, cmd[2:0], 11'b0});
    chk(last_rises == 16, "R4 rises per frame", last_rises, 16);
    chk(cs_n && !sclk && !mosi, "R4 R5 idle lines", {cs_n, sclk, mosi}, 3'b100);
  endtask

  initial begin
    int busy, nfr;
    repeat (3) @(negedge clk);
    // R1
    chk(cmd_rdata == 8'h80, "R1 readback", cmd_rdata, 8'h80);
    chk(res_lo == 8'h00 && res_hi == 8'h00, "R1 result", {res_hi, res_lo}, 0);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 lines", {cs_n, sclk}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_rdata == 8'h80 && cs_n, "R1 after release", cmd_rdata, 8'h80);

    for (int i = 0; i < NV; i++) begin
      acq(VEC[i][10:3], 0, 8'h00, busy, nfr);
      check_acq(VEC[i][10:3], VEC[i][2:0], busy, nfr);
    end

    // R9: write mid-acquisition (double ch5) is ignored; single ch4 converts ch1
    acq(8'h14, 20, 8'h05, busy, nfr);
    check_acq(8'h14, 3'd1, busy, nfr);
    chk(cmd_rdata == 8'h94, "R9 readback kept", cmd_rdata, 8'h94);
    // R9: next single shows ch4 (not ch5) was sent
    acq(8'h10, 0, 8'h00, busy, nfr);
    check_acq(8'h10, 3'd4, busy, nfr);
    // R9: write in last busy cycle before capture is ignored too
    acq(8'h13, 32*D - 1, 8'h16, busy, nfr);
    check_acq(8'h13, 3'd0, busy, nfr);
    repeat (4) @(negedge clk);
    chk(cmd_rdata == 8'h93 && cs_n, "R9 no restart", cmd_rdata, 8'h93);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule